// File: doc/BRIEF.md
# Integer Shift Unit with Flags

A purely combinational shift unit for an integer execution stage. It takes a 64-bit operand, an 8-bit shift count, an operation select, an operand-size select and the current arithmetic flags. It returns the shifted value and a new set of carry, overflow, sign, zero, parity and auxiliary flags. The unit works at 8, 16, 32 or 64 bits. Operand bits above the selected size are ignored, and result bits above it are driven low.

Three operations are supported: left shift with zero fill, arithmetic right shift with sign fill, and logical right shift with zero fill. The count is masked according to the operand size before use. A masked count of zero returns the operand unchanged and leaves every flag as it came in. Flags that an instruction set would leave undefined are given fixed values here, so the block's behaviour is fully deterministic.

Top module: `shift_unit`

## Requirements
- R1: The count is reduced to its low 5 bits for sizes 8, 16 and 32, and to its low 6 bits for size 64. Size encoding: `size_sel` 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.
- R2: Operation encoding: `op_sel` 0 and 3 = left shift, 1 = arithmetic right, 2 = logical right. A left shift fills vacated low bits with 0.
- R3: A logical right shift fills vacated high bits with 0. An arithmetic right shift fills them with the sign of the unshifted operand. An arithmetic right shift by at least the width gives all sign bits, with carry equal to the sign.
- R4: Carry is the last bit shifted out: operand bit (width − count) for left shifts and bit (count − 1) for right shifts. For a logical shift whose count exceeds the width, carry is 0.
- R5: For a masked count of 0, the result equals the operand at the selected width and all six flag outputs equal their inputs.
- R6: For a masked count of 1, overflow is set as follows. Left shift: result MSB XOR carry. Arithmetic right: 0. Logical right: MSB of the original operand.
- R7: For a masked count above 1, overflow is 0. For any nonzero masked count, the auxiliary flag is 0.
- R8: For a nonzero masked count, sign is the result MSB at the selected width, and zero is set when the result bits of that width are all 0. Parity is set when result bits [7:0] hold an even number of ones.
- R9: Result bits above the selected width are 0, and operand bits above it have no effect.
- R10: An arithmetic right shift rounds toward negative infinity. For example, 8-bit 0xF7 (−9) shifted by 2 gives 0xFD (−3) with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 0/3 left, 1 arithmetic right, 2 logical right |
| size_sel | input | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| operand | input | 64 | Value to shift, right-aligned |
| count | input | 8 | Requested shift count before masking |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| sf_in | input | 1 | Incoming sign flag |
| zf_in | input | 1 | Incoming zero flag |
| pf_in | input | 1 | Incoming parity flag |
| af_in | input | 1 | Incoming auxiliary flag |
| result | output | 64 | Shifted value, zero above the selected width |
| cf_out | output | 1 | Carry flag out |
| of_out | output | 1 | Overflow flag out |
| sf_out | output | 1 | Sign flag out |
| zf_out | output | 1 | Zero flag out |
| pf_out | output | 1 | Parity flag out |
| af_out | output | 1 | Auxiliary flag out |

## Verification
The embedded assertions check, on every evaluation, properties that hold for any input:
- the masked count stays within range for the narrow sizes;
- the fill bit is correct next to the shifted field;
- the high result bits stay clear above the selected width;
- zero-count pass-through of flags and operand;
- overflow and auxiliary are forced low for multi-bit shifts.

The exact carry position, the single-bit overflow rules, parity and the rounding of negative values can only be shown by the bench. Its bit-serial reference model runs directed corner vectors and a large randomised mix at every size, including counts equal to, above and wrapping past the width.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

   typedef enum logic [1:0] {
      SH_LEFT     = 2'b00,
      SH_ARITH_R  = 2'b01,
      SH_LOGIC_R  = 2'b10,
      SH_LEFT_ALT = 2'b11
   } shift_op_e;

   typedef struct packed {
      logic af;
      logic pf;
      logic zf;
      logic sf;
      logic of;
      logic cf;
   } shift_flags_t;

   function automatic logic op_is_left(shift_op_e op);
      return (op == SH_LEFT) || (op == SH_LEFT_ALT);
   endfunction

endpackage

// File: rtl/shift_count_mask.sv
module shift_count_mask #(
   parameter int CNT_W     = 8,
   parameter int SHAMT_W   = 6,
   parameter int SIZE_W    = 2,
   parameter int NUM_SIZES = 4
) (
   input  logic [CNT_W-1:0]   count,
   input  logic [SIZE_W-1:0]  size_sel,
   output logic [SHAMT_W-1:0] shamt,
   output logic               cnt_zero,
   output logic               cnt_one
);

   localparam logic [SIZE_W-1:0] WIDEST = SIZE_W'(NUM_SIZES - 1);

   logic unused_cnt_hi;
   assign unused_cnt_hi = ^count[CNT_W-1:SHAMT_W];

   always_comb begin
      if (size_sel == WIDEST)
         shamt = count[SHAMT_W-1:0];
      else
         shamt = {1'b0, count[SHAMT_W-2:0]};
      cnt_zero = (shamt == '0);
      cnt_one  = (shamt == SHAMT_W'(1));
   end

   always_comb begin
      p_narrow_count_range_r1: assert ((size_sel == WIDEST) || (shamt < SHAMT_W'(1 << (SHAMT_W - 1))))
         else $error("narrow size count not masked");
      p_count_low_bits_kept_r1: assert (shamt[SHAMT_W-2:0] == count[SHAMT_W-2:0])
         else $error("count low bits altered by masking");
   end

endmodule

// File: rtl/shift_lane.sv
module shift_lane
   import shift_unit_pkg::*;
#(
   parameter int W       = 8,
   parameter int SHAMT_W = 6
) (
   input  shift_op_e          op,
   input  logic [W-1:0]       a,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [W-1:0]       res,
   output logic               cf
);

   logic [W:0]        left_x;
   logic [W:0]        logic_x;
   logic signed [W:0] arith_x;

   always_comb begin
      left_x  = {1'b0, a} << shamt;
      logic_x = {a, 1'b0} >> shamt;
      arith_x = $signed({a, 1'b0}) >>> shamt;
      unique case (op)
         SH_ARITH_R: begin
            res = arith_x[W:1];
            cf  = arith_x[0];
         end
         SH_LOGIC_R: begin
            res = logic_x[W:1];
            cf  = logic_x[0];
         end
         default: begin
            res = left_x[W-1:0];
            cf  = left_x[W];
         end
      endcase
   end

   always_comb begin
      p_left_zero_fill_r2: assert (!(op_is_left(op) && shamt != '0) || res[0] == 1'b0)
         else $error("left shift did not zero fill");
      p_arith_sign_fill_r3: assert (!(op == SH_ARITH_R) || res[W-1] == a[W-1])
         else $error("arithmetic right shift lost the sign");
      p_logic_zero_fill_r3: assert (!(op == SH_LOGIC_R && shamt != '0) || res[W-1] == 1'b0)
         else $error("logical right shift did not zero fill");
   end

endmodule

// File: rtl/shift_core.sv
module shift_core
   import shift_unit_pkg::*;
#(
   parameter int MAX_W     = 64,
   parameter int MIN_W     = 8,
   parameter int SHAMT_W   = 6,
   parameter int SIZE_W    = 2,
   parameter int NUM_SIZES = 4
) (
   input  shift_op_e          op,
   input  logic [SIZE_W-1:0]  size_sel,
   input  logic [MAX_W-1:0]   operand,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [MAX_W-1:0]   result,
   output logic               cf_raw,
   output logic               orig_msb
);

   logic [MAX_W-1:0] lane_res [NUM_SIZES];
   logic             lane_cf  [NUM_SIZES];
   logic             lane_msb [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
      localparam int LW = MIN_W << g;
      logic [LW-1:0] r;

      shift_lane #(.W(LW), .SHAMT_W(SHAMT_W)) u_lane (
         .op    (op),
         .a     (operand[LW-1:0]),
         .shamt (shamt),
         .res   (r),
         .cf    (lane_cf[g])
      );

      assign lane_msb[g] = operand[LW-1];
      if (LW < MAX_W) begin : g_ext
         assign lane_res[g] = {{(MAX_W-LW){1'b0}}, r};
      end else begin : g_full
         assign lane_res[g] = r;
      end
   end

   assign result   = lane_res[size_sel];
   assign cf_raw   = lane_cf[size_sel];
   assign orig_msb = lane_msb[size_sel];

   always_comb begin
      p_upper_bits_clear_r9: assert (size_sel == SIZE_W'(NUM_SIZES - 1) ||
                                     (result >> (MIN_W << size_sel)) == '0)
         else $error("result bits above the selected width are set");
   end

endmodule

// File: rtl/shift_flags.sv
module shift_flags
   import shift_unit_pkg::*;
#(
   parameter int MAX_W     = 64,
   parameter int MIN_W     = 8,
   parameter int SIZE_W    = 2,
   parameter int NUM_SIZES = 4
) (
   input  shift_op_e        op,
   input  logic [SIZE_W-1:0] size_sel,
   input  logic [MAX_W-1:0] result,
   input  logic             cf_raw,
   input  logic             orig_msb,
   input  logic             cnt_zero,
   input  logic             cnt_one,
   input  shift_flags_t     flags_in,
   output shift_flags_t     flags_out
);

   localparam logic [MAX_W-1:0] ONE = MAX_W'(1);

   logic [MAX_W-1:0] wmask;
   logic             res_msb;
   logic             of_single;

   always_comb begin
      if (size_sel == SIZE_W'(NUM_SIZES - 1))
         wmask = '1;
      else
         wmask = (ONE << (MIN_W << size_sel)) - ONE;
      res_msb = result[(MIN_W << size_sel) - 1];

      unique case (op)
         SH_ARITH_R: of_single = 1'b0;
         SH_LOGIC_R: of_single = orig_msb;
         default:    of_single = res_msb ^ cf_raw;
      endcase

      if (cnt_zero) begin
         flags_out = flags_in;
      end else begin
         flags_out.cf = cf_raw;
         flags_out.of = cnt_one ? of_single : 1'b0;
         flags_out.sf = res_msb;
         flags_out.zf = ((result & wmask) == '0);
         flags_out.pf = ~^result[7:0];
         flags_out.af = 1'b0;
      end
   end

   always_comb begin
      p_zero_count_keeps_flags_r5: assert (!cnt_zero || flags_out == flags_in)
         else $error("zero count altered flags");
      p_no_overflow_r7: assert (cnt_zero || cnt_one || !flags_out.of)
         else $error("overflow set on multi-bit shift");
      p_aux_clear_r7: assert (cnt_zero || !flags_out.af)
         else $error("auxiliary flag set on nonzero shift");
      p_arith_single_of_r6: assert (!(cnt_one && op == SH_ARITH_R) || !flags_out.of)
         else $error("arithmetic single shift set overflow");
   end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
   import shift_unit_pkg::*;
#(
   parameter int MAX_W = 64,
   parameter int MIN_W = 8,
   parameter int CNT_W = 8
) (
   input  logic [1:0]       op_sel,
   input  logic [1:0]       size_sel,
   input  logic [MAX_W-1:0] operand,
   input  logic [CNT_W-1:0] count,
   input  logic             cf_in,
   input  logic             of_in,
   input  logic             sf_in,
   input  logic             zf_in,
   input  logic             pf_in,
   input  logic             af_in,
   output logic [MAX_W-1:0] result,
   output logic             cf_out,
   output logic             of_out,
   output logic             sf_out,
   output logic             zf_out,
   output logic             pf_out,
   output logic             af_out
);

   localparam int NUM_SIZES = $clog2(MAX_W / MIN_W) + 1;
   localparam int SIZE_W    = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1;
   localparam int SHAMT_W   = $clog2(MAX_W);

   if (MAX_W != (MIN_W << (NUM_SIZES - 1))) begin : g_bad_width
      $error("MAX_W must be MIN_W times a power of two");
   end
   if (MIN_W < 8) begin : g_bad_min
      $error("MIN_W must cover the parity byte");
   end
   if (SIZE_W != 2) begin : g_bad_size
      $error("size select port is two bits wide");
   end
   if (CNT_W < SHAMT_W) begin : g_bad_cnt
      $error("count port narrower than the shift amount");
   end

   shift_op_e          op;
   logic [SHAMT_W-1:0] shamt;
   logic               cnt_zero;
   logic               cnt_one;
   logic               cf_raw;
   logic               orig_msb;
   shift_flags_t       flags_in;
   shift_flags_t       flags_out;

   assign op       = shift_op_e'(op_sel);
   assign flags_in = '{af: af_in, pf: pf_in, zf: zf_in, sf: sf_in, of: of_in, cf: cf_in};

   shift_count_mask #(
      .CNT_W(CNT_W), .SHAMT_W(SHAMT_W), .SIZE_W(SIZE_W), .NUM_SIZES(NUM_SIZES)
   ) u_mask (
      .count    (count),
      .size_sel (size_sel),
      .shamt    (shamt),
      .cnt_zero (cnt_zero),
      .cnt_one  (cnt_one)
   );

   shift_core #(
      .MAX_W(MAX_W), .MIN_W(MIN_W), .SHAMT_W(SHAMT_W), .SIZE_W(SIZE_W), .NUM_SIZES(NUM_SIZES)
   ) u_core (
      .op       (op),
      .size_sel (size_sel),
      .operand  (operand),
      .shamt    (shamt),
      .result   (result),
      .cf_raw   (cf_raw),
      .orig_msb (orig_msb)
   );

   shift_flags #(
      .MAX_W(MAX_W), .MIN_W(MIN_W), .SIZE_W(SIZE_W), .NUM_SIZES(NUM_SIZES)
   ) u_flags (
      .op        (op),
      .size_sel  (size_sel),
      .result    (result),
      .cf_raw    (cf_raw),
      .orig_msb  (orig_msb),
      .cnt_zero  (cnt_zero),
      .cnt_one   (cnt_one),
      .flags_in  (flags_in),
      .flags_out (flags_out)
   );

   assign cf_out = flags_out.cf;
   assign of_out = flags_out.of;
   assign sf_out = flags_out.sf;
   assign zf_out = flags_out.zf;
   assign pf_out = flags_out.pf;
   assign af_out = flags_out.af;

   always_comb begin
      p_zero_count_passes_r5: assert (!cnt_zero || size_sel != 2'd3 || result == operand)
         else $error("zero count altered the operand");
      p_zero_count_low_byte_r5: assert (!cnt_zero || result[7:0] == operand[7:0])
         else $error("zero count altered the low byte");
   end

endmodule

// File: tb/shift_unit_tb.sv
module shift_unit_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  op_sel = '0;
   logic [1:0]  size_sel = '0;
   logic [63:0] operand = '0;
   logic [7:0]  count = '0;
   logic [5:0]  fin = '0;
   logic [63:0] result;
   logic        cf_out, of_out, sf_out, zf_out, pf_out, af_out;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   shift_unit u_dut (
      .op_sel(op_sel), .size_sel(size_sel), .operand(operand), .count(count),
      .cf_in(fin[0]), .of_in(fin[1]), .sf_in(fin[2]), .zf_in(fin[3]),
      .pf_in(fin[4]), .af_in(fin[5]),
      .result(result), .cf_out(cf_out), .of_out(of_out), .sf_out(sf_out),
      .zf_out(zf_out), .pf_out(pf_out), .af_out(af_out)
   );

   // Bit-serial model; flag vector order {af,pf,zf,sf,of,cf}
   task automatic model(input logic [1:0] op, input logic [1:0] sz, input logic [63:0] a,
                        input logic [7:0] cnt, input logic [5:0] fi,
                        output logic [63:0] r, output logic [5:0] fo, output int c);
      int w;
      logic [63:0] m, d;
      logic sign, cf, of;
      w = 8 << sz;
      c = (sz == 2'd3) ? int'(cnt & 8'h3f) : int'(cnt & 8'h1f);
      m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      d = a & m;
      sign = d[w-1];
      cf = 1'b0;
      for (int i = 0; i < c; i++) begin
         if (op == 2'd1 || op == 2'd2) begin
            cf = d[0];
            d = d >> 1;
            if (op == 2'd1 && sign) d[w-1] = 1'b1;
         end else begin
            cf = d[w-1];
            d = (d << 1) & m;
         end
      end
      r = d;
      if (c == 0) begin
         fo = fi;
      end else begin
         if (c == 1) begin
            if (op == 2'd1)      of = 1'b0;
            else if (op == 2'd2) of = a[w-1];
            else                 of = d[w-1] ^ cf;
         end else of = 1'b0;
         fo = {1'b0, ~^d[7:0], (d == 0), d[w-1], of, cf};
      end
   endtask

   task automatic check_vec(input string tag);
      logic [63:0] er;
      logic [5:0]  ef, af;
      int c;
      bit bad;
      string rt;
      model(op_sel, size_sel, operand, count, fin, er, ef, c);
      af = {af_out, pf_out, zf_out, sf_out, of_out, cf_out};
      n_checks++;
      bad = 0;
      if (c == 0) rt = "R5";
      else if (op_sel == 2'd1 || op_sel == 2'd2) rt = "R3";
      else rt = "R2";
      if (result !== er) begin
         bad = 1;
         $display("FAIL %s %s R9 result op=%0d sz=%0d cnt=%0d act=%h exp=%h",
                  tag, rt, op_sel, size_sel, count, result, er);
      end
      if (af[0] !== ef[0]) begin
         bad = 1;
         $display("FAIL %s %s R4 carry act=%b exp=%b", tag, (c == 0) ? "R5" : "", af[0], ef[0]);
      end
      if (af[1] !== ef[1]) begin
         bad = 1;
         $display("FAIL %s %s overflow act=%b exp=%b", tag,
                  (c == 0) ? "R5" : (c == 1) ? "R6" : "R7", af[1], ef[1]);
      end
      if (af[4:2] !== ef[4:2]) begin
         bad = 1;
         $display("FAIL %s %s R8 sf/zf/pf act=%b exp=%b", tag, (c == 0) ? "R5" : "", af[4:2], ef[4:2]);
      end
      if (af[5] !== ef[5]) begin
         bad = 1;
         $display("FAIL %s %s R7 aux act=%b exp=%b", tag, (c == 0) ? "R5" : "", af[5], ef[5]);
      end
      if (bad) n_fail++;
   endtask

   task automatic apply(input logic [1:0] op, input logic [1:0] sz, input logic [63:0] a,
                        input logic [7:0] cnt, input logic [5:0] fi, input string tag);
      @(posedge clk);
      #1;
      op_sel = op; size_sel = sz; operand = a; count = cnt; fin = fi;
      @(negedge clk);
      check_vec(tag);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_vec("reset_state");
      rst = 1'b0;

      // R10: -9 >> 2 arithmetic = -3, carry 1
      apply(2'd1, 2'd0, 64'hF7, 8'd2, 6'b0, "R10");
      apply(2'd1, 2'd3, 64'hFFFF_FFFF_FFFF_FFF7, 8'd2, 6'b0, "R10");
      // R1: masking of count
      apply(2'd0, 2'd0, 64'h81, 8'h21, 6'b0, "R1");
      apply(2'd0, 2'd2, 64'h1234_5678, 8'd32, 6'b101010, "R1");
      apply(2'd2, 2'd3, 64'h8000_0000_0000_0001, 8'h41, 6'b0, "R1");
      apply(2'd0, 2'd3, 64'h1, 8'd63, 6'b0, "R1");
      // R5: zero count keeps flags
      apply(2'd1, 2'd1, 64'h8001, 8'd0, 6'b111111, "R5");
      apply(2'd2, 2'd0, 64'h0, 8'hE0, 6'b010101, "R5");
      // R6: single-bit overflow per op
      apply(2'd0, 2'd0, 64'h40, 8'd1, 6'b0, "R6");
      apply(2'd3, 2'd1, 64'hC000, 8'd1, 6'b0, "R6");
      apply(2'd2, 2'd2, 64'h8000_0000, 8'd1, 6'b0, "R6");
      apply(2'd1, 2'd0, 64'h80, 8'd1, 6'b0, "R6");
      // R3/R4: counts equal to and beyond width
      apply(2'd0, 2'd0, 64'h01, 8'd8, 6'b0, "R4");
      apply(2'd2, 2'd0, 64'h80, 8'd8, 6'b0, "R4");
      apply(2'd2, 2'd0, 64'hFF, 8'd9, 6'b0, "R4");
      apply(2'd1, 2'd0, 64'h80, 8'd20, 6'b0, "R3");
      apply(2'd1, 2'd1, 64'h7FFF, 8'd31, 6'b0, "R3");
      // R9: ignored upper operand bits
      apply(2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FF40, 8'd3, 6'b0, "R9");
      apply(2'd2, 2'd1, 64'hDEAD_BEEF_CAFE_0001, 8'd1, 6'b0, "R9");
      // R7/R8: multi-bit flags and zero result
      apply(2'd0, 2'd2, 64'h0000_0003, 8'd31, 6'b000010, "R7");
      apply(2'd2, 2'd3, 64'h0F, 8'd4, 6'b100000, "R8");

      for (int i = 0; i < 4000; i++) begin
         logic [7:0] cnt;
         cnt = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'($urandom_range(0, 3));
         apply(2'($urandom), 2'($urandom), {32'($urandom), 32'($urandom)}, cnt,
               6'($urandom), "random");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule